// File: doc/BRIEF.md
# Integer Multiply and Divide Unit

This unit runs the eight integer multiply, divide and remainder operations of a 32-bit RISC-V core on two register operands. It sits beside the ALU in the execute stage. The decoder passes a 4-bit function code, which is a marker bit for the extension plus the instruction's funct3 field, together with the rs1 and rs2 values and a one-cycle start strobe. The unit answers with a 32-bit result and a one-cycle done strobe.

Multiplication is a single-cycle operation. It returns the low word of the 64-bit product, or the high word with each operand read as signed or unsigned. Division uses a restoring shift-subtract loop on operand magnitudes and produces one quotient bit per cycle. Signs are applied after the loop, so signed and unsigned division share one datapath. A zero divisor and the single signed overflow case never trap. Both are caught when the operation is accepted and return their architectural values one cycle later. Stalling, write-back and decode stay with the surrounding pipeline, which sees only busy and done.

Top module: `muldiv_unit`

## Requirements
- R1: `func_i[3]` = 1 marks a valid operation, and `func_i[2:0]` picks it: 000 MUL, 001 MULH, 010 MULHSU, 011 MULHU, 100 DIV, 101 DIVU, 110 REM, 111 REMU. A start with `func_i[3]` = 0 is ignored. It raises no done and leaves the result unchanged.
- R2: MUL returns bits [31:0] of the product of `op_a_i` and `op_b_i`.
- R3: MULH, MULHSU and MULHU return bits [63:32] of the product. The operands are signed×signed for MULH, `op_a_i` signed × `op_b_i` unsigned for MULHSU, and unsigned×unsigned for MULHU.
- R4: For any multiply, done is high and the result is valid in the cycle after the accepting clock edge.
- R5: DIV and DIVU give the quotient truncated toward zero. REM gives a remainder with the sign of the dividend, and REMU is fully unsigned. For every non-exceptional case, dividend = divisor × quotient + remainder.
- R6: A division that is not exceptional holds `busy_o` high from the accepting edge onward. Done rises 34 cycles (XLEN+2) after that edge, and done is never high while busy is high.
- R7: A zero divisor finishes in one cycle. DIV and DIVU return all ones, and REM and REMU return the dividend unchanged.
- R8: A dividend of −2^31 with a divisor of −1 finishes in one cycle. DIV returns −2^31 (0x80000000) and REM returns 0. DIVU and REMU treat these operands as a normal unsigned division.
- R9: A start while `busy_o` is high is ignored, including a start at the edge where the division completes.
- R10: Done is a one-cycle pulse per accepted operation. `result_o` changes only in a cycle where done is high and then holds until the next done.
- R11: An active-low asynchronous reset clears busy, done and the result register, and abandons any division in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted when not busy |
| func_i | input | 4 | Operation code: valid marker in bit 3, funct3 in bits 2:0 |
| op_a_i | input | 32 | rs1 operand (dividend, multiplicand) |
| op_b_i | input | 32 | rs2 operand (divisor, multiplier) |
| busy_o | output | 1 | Iterative division in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| result_o | output | 32 | Result register |

## Verification
Two events can meet in one cycle: a new start and the completion of a division. A start driven in the last busy cycle, where the completing edge sees busy still set, must be dropped. A second start driven in the cycle where done is high, after busy has dropped, must be accepted and produce its own done one cycle later. The bench provokes both by counting cycles from a division's start. It judges them by the result the done pulse carries: the division's quotient for the dropped start, and the multiply's product for the accepted one. It also uses the absence of any extra done pulse.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned FUNC_W = 4;

  typedef enum logic [2:0] {
    OP_MUL    = 3'b000,
    OP_MULH   = 3'b001,
    OP_MULHSU = 3'b010,
    OP_MULHU  = 3'b011,
    OP_DIV    = 3'b100,
    OP_DIVU   = 3'b101,
    OP_REM    = 3'b110,
    OP_REMU   = 3'b111
  } op_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul import muldiv_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input  op_e            op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o
);
  localparam int unsigned PW = 2 * W;

  logic          a_sgn, b_sgn;
  logic [PW-1:0] a_x, b_x, prod;

  always_comb begin
    a_sgn = (op_i == OP_MULH) || (op_i == OP_MULHSU);
    b_sgn = (op_i == OP_MULH);
  end

  // sign-extend to 2W; the low 2W bits of the wrapped product are exact
  assign a_x  = {{W{a_sgn & a_i[W-1]}}, a_i};
  assign b_x  = {{W{b_sgn & b_i[W-1]}}, b_i};
  assign prod = a_x * b_x;

  assign res_o = (op_i == OP_MUL) ? prod[W-1:0] : prod[PW-1:W];
endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core import muldiv_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         fin_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  logic [W-1:0]  rem_q, quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, fin_q;

  logic [W:0]    shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, dvs_q};
    fits    = (shifted >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        rem_q <= '0;
        quo_q <= dividend_i;
        dvs_q <= divisor_i;
        cnt_q <= STEPS;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o = fin_q;
  assign quo_o = quo_q;
  assign rem_o = rem_q;
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit import muldiv_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [W-1:0]      op_a_i,
  input  logic [W-1:0]      op_b_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [W-1:0]      result_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONE = '1;

  op_e          op;
  logic         accept, is_div, div_sgn, want_rem;
  logic         a_neg, b_neg, div_zero, div_ovf, core_load;
  logic [W-1:0] mag_a, mag_b, mul_res;
  logic         core_fin;
  logic [W-1:0] core_quo, core_rem;

  logic         busy_q, done_q, neg_quo_q, neg_rem_q, want_rem_q;
  logic [W-1:0] result_q;

  assign op       = op_e'(func_i[2:0]);
  assign accept   = start_i & ~busy_q & func_i[FUNC_W-1];
  assign is_div   = func_i[2];
  assign div_sgn  = ~func_i[0];
  assign want_rem = func_i[1];

  always_comb begin
    a_neg     = div_sgn & op_a_i[W-1];
    b_neg     = div_sgn & op_b_i[W-1];
    mag_a     = a_neg ? (~op_a_i + 1'b1) : op_a_i;
    mag_b     = b_neg ? (~op_b_i + 1'b1) : op_b_i;
    div_zero  = (op_b_i == '0);
    div_ovf   = div_sgn & (op_a_i == MIN_NEG) & (op_b_i == ALL_ONE);
    core_load = accept & is_div & ~div_zero & ~div_ovf;
  end

  muldiv_mul #(.W(W)) u_mul (
    .op_i  (op),
    .a_i   (op_a_i),
    .b_i   (op_b_i),
    .res_o (mul_res)
  );

  muldiv_div_core #(.W(W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (core_load),
    .dividend_i (mag_a),
    .divisor_i  (mag_b),
    .fin_o      (core_fin),
    .quo_o      (core_quo),
    .rem_o      (core_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      result_q   <= '0;
      neg_quo_q  <= 1'b0;
      neg_rem_q  <= 1'b0;
      want_rem_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (!is_div) begin
          result_q <= mul_res;
          done_q   <= 1'b1;
        end else if (div_zero) begin
          result_q <= want_rem ? op_a_i : ALL_ONE;
          done_q   <= 1'b1;
        end else if (div_ovf) begin
          result_q <= want_rem ? '0 : MIN_NEG;
          done_q   <= 1'b1;
        end else begin
          busy_q     <= 1'b1;
          neg_quo_q  <= a_neg ^ b_neg;
          neg_rem_q  <= a_neg;
          want_rem_q <= want_rem;
        end
      end else if (core_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (want_rem_q) result_q <= neg_rem_q ? (~core_rem + 1'b1) : core_rem;
        else            result_q <= neg_quo_q ? (~core_quo + 1'b1) : core_quo;
      end
    end
  end

  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign result_o = result_q;
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk import muldiv_pkg::*; #(
  parameter int unsigned W = XLEN
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [W-1:0]      op_a_i,
  input logic [W-1:0]      op_b_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [W-1:0]      result_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  assert_ignore_func_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !func_i[3]) |=> !done_o);

  assert_mul_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && func_i[3] && !func_i[2]) |=> done_o);

  assert_busy_no_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);

  assert_div_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && func_i[3] && func_i[2] && op_b_i == '0) |=>
      (done_o && result_o == ($past(func_i[1]) ? $past(op_a_i) : {W{1'b1}})));

  assert_div_ovf_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && func_i[3] && func_i[2] && !func_i[0] &&
     op_a_i == MIN_NEG && op_b_i == {W{1'b1}}) |=>
      (done_o && result_o == ($past(func_i[1]) ? '0 : MIN_NEG)));

  assert_hold_result_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .func_i   (func_i),
  .op_a_i   (op_a_i),
  .op_b_i   (op_b_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o)
);

// File: tb/tb_muldiv_unit.sv
module tb_muldiv_unit;
  localparam int W = 32;
  localparam int NV = 21;
  localparam logic [31:0] MINV = 32'h8000_0000;

  // {func, op_a, op_b, expected}
  localparam logic [99:0] VECS [NV] = '{
    {4'h8, 32'd7,          32'd6,          32'd42},         // R2
    {4'h8, 32'hFFFF_FFFD,  32'd5,          32'hFFFF_FFF1},  // R2
    {4'h9, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'h0000_0000},  // R3 MULH
    {4'hB, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFE},  // R3 MULHU
    {4'hA, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'hFFFF_FFFF},  // R3 MULHSU
    {4'h9, 32'h8000_0000,  32'h8000_0000,  32'h4000_0000},  // R3
    {4'hC, 32'd20,         32'hFFFF_FFFD,  32'hFFFF_FFFA},  // R5 DIV
    {4'hE, 32'd20,         32'hFFFF_FFFD,  32'd2},          // R5 REM
    {4'hE, 32'hFFFF_FFEC,  32'd3,          32'hFFFF_FFFE},  // R5 REM
    {4'hD, 32'hFFFF_FFFF,  32'd16,         32'h0FFF_FFFF},  // R5 DIVU
    {4'hF, 32'hFFFF_FFFF,  32'd16,         32'd15},         // R5 REMU
    {4'hC, 32'hFFFF_FFF9,  32'd2,          32'hFFFF_FFFD},  // R5
    {4'hC, 32'd5,          32'd0,          32'hFFFF_FFFF},  // R7
    {4'hD, 32'd5,          32'd0,          32'hFFFF_FFFF},  // R7
    {4'hE, 32'hFFFF_FFF9,  32'd0,          32'hFFFF_FFF9},  // R7
    {4'hF, 32'd1234,       32'd0,          32'd1234},       // R7
    {4'hC, 32'h8000_0000,  32'hFFFF_FFFF,  32'h8000_0000},  // R8
    {4'hE, 32'h8000_0000,  32'hFFFF_FFFF,  32'd0},          // R8
    {4'hD, 32'h8000_0000,  32'hFFFF_FFFF,  32'd0},          // R8 unsigned
    {4'hF, 32'h8000_0000,  32'hFFFF_FFFF,  32'h8000_0000},  // R8 unsigned
    {4'hC, 32'h8000_0000,  32'd1,          32'h8000_0000}   // R5
  };

  logic        clk, rst_n, start;
  logic [3:0]  func;
  logic [31:0] op_a, op_b;
  logic        busy, done;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  muldiv_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .func_i(func),
    .op_a_i(op_a), .op_b_i(op_b), .busy_o(busy), .done_o(done), .result_o(result)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    if (!f[2]) return 1;
    if (b == 32'd0) return 1;
    if (!f[0] && a == MINV && b == 32'hFFFF_FFFF) return 1;
    return W + 2;
  endfunction

  task automatic run_op(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b,
                        output logic [31:0] res, output int lat, output bit busy1);
    @(negedge clk);
    start = 1'b1; func = f; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    busy1 = busy;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    res = result;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] res, prev;
    int lat, el;
    bit b1;
    start = 0; func = 0; op_a = 0; op_b = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0, "R11 reset busy/done", {30'd0, busy, done}, 32'd0);
    chk(result == 0, "R11 reset result", result, 32'd0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      run_op(VECS[i][99:96], VECS[i][95:64], VECS[i][63:32], res, lat, b1);
      el = exp_lat(VECS[i][99:96], VECS[i][95:64], VECS[i][63:32]);
      chk(res == VECS[i][31:0], $sformatf("R2/R3/R5/R7/R8 vec %0d result", i), res, VECS[i][31:0]);
      chk(lat == el, $sformatf("R4/R6 vec %0d latency", i), lat, el);
      if (el > 1) chk(b1 == 1'b1, $sformatf("R6 vec %0d busy", i), {31'd0, b1}, 32'd1);
      // R10: done lasts one cycle, result holds
      @(negedge clk);
      chk(done == 0, "R10 done pulse", {31'd0, done}, 32'd0);
      chk(result == VECS[i][31:0], "R10 result hold", result, VECS[i][31:0]);
    end

    // R1: invalid marker bit ignored
    prev = result;
    @(negedge clk); start = 1; func = 4'h0; op_a = 32'd3; op_b = 32'd4;
    @(negedge clk); start = 0;
    chk(done == 0, "R1 no done on invalid code", {31'd0, done}, 32'd0);
    repeat (2) @(negedge clk);
    chk(result == prev, "R1 result unchanged", result, prev);

    // R9: start while busy dropped; start at completing edge dropped; start in done cycle taken
    @(negedge clk); start = 1; func = 4'hD; op_a = 32'd100; op_b = 32'd7;
    @(negedge clk); func = 4'h8; op_a = 32'd7; op_b = 32'd6;   // busy here
    @(negedge clk); start = 0;
    lat = 2;
    while (lat < W + 1) begin @(negedge clk); lat++; end       // lat = 33, busy still set
    chk(busy == 1 && done == 0, "R9 last busy cycle", {30'd0, busy, done}, 32'd2);
    start = 1; func = 4'h8; op_a = 32'd9; op_b = 32'd9;
    @(negedge clk); start = 0;
    chk(done == 1, "R9 div done at 34", {31'd0, done}, 32'd1);
    chk(result == 32'd14, "R9 div result, starts ignored", result, 32'd14);
    start = 1; func = 4'h8; op_a = 32'd7; op_b = 32'd6;        // in done cycle, not busy
    @(negedge clk); start = 0;
    chk(done == 1 && result == 32'd42, "R9 start in done cycle accepted", result, 32'd42);
    @(negedge clk);
    chk(done == 0, "R9 no extra done", {31'd0, done}, 32'd0);

    // R11: reset during division
    @(negedge clk); start = 1; func = 4'hC; op_a = 32'd1000; op_b = 32'd3;
    @(negedge clk); start = 0;
    repeat (10) @(negedge clk);
    rst_n = 0;
    #1;
    chk(busy == 0 && done == 0, "R11 mid-run reset busy", {30'd0, busy, done}, 32'd0);
    chk(result == 0, "R11 mid-run reset result", result, 32'd0);
    @(negedge clk); rst_n = 1;
    b1 = 0;
    repeat (40) begin @(negedge clk); if (done) b1 = 1; end
    chk(b1 == 0, "R11 abandoned division gives no done", {31'd0, b1}, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule